// File: doc/BRIEF.md
# PHY Event Interrupt Register

This block is a 16-bit management register that gathers eight PHY events into sticky status bits and turns them into one interrupt line. The low byte holds the status bits. Each bit is set by its event and can only be cleared by a read of the register. The high byte holds one enable bit per status bit. When an enabled status bit is set, the interrupt output goes to its active level. An external polarity input selects that level.

Management logic reaches the register through a decoded select, a read strobe, a write strobe and a 16-bit write data bus. Read data is combinational while the register is selected. A selected read returns the current contents and clears the whole status byte at the same clock edge. An event that arrives in the clearing cycle is never lost.

Each event input is either a one-cycle strobe or a level that is edge-detected inside the block. The `EDGE_MASK` parameter chooses which inputs are edge-detected.

Top module: `phy_irq_reg`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it goes low, both bytes clear to zero. Read data is then 0x0000 and the interrupt output sits at its inactive level.
- R2: A strobe-type event input (bits 7, 5, 4 and 3 with the default mask) sets its status bit at each clock edge where the input is 1. The bit stays set until a clearing read.
- R3: An edge-type event input (bits 6, 2, 1 and 0 with the default mask) sets its status bit only on a 0-to-1 change seen between two clock edges. A level held high after a clear does not set the bit again.
- R4: While `sel` is 1, `rdata` equals {enable byte, status byte} of the current state. A cycle with `sel` and `rd_en` both 1 clears all eight status bits at the next edge, and `rdata` still shows the value from before the clear.
- R5: An event set in the same cycle as a clearing read leaves its status bit at 1 after that edge.
- R6: A cycle with `sel` and `wr_en` both 1 loads `wdata[15:8]` into the enable byte. `wdata[7:0]` has no effect on the status byte.
- R7: The interrupt is pending when any status bit and its enable bit are both 1. With `polarity` = 1, `irq_o` is 1 while pending and 0 otherwise. With `polarity` = 0 the output is inverted.
- R8: When `sel` is 0, `rd_en` and `wr_en` have no effect and `rdata` is 0x0000.
- R9: Status bits 7 down to 0 map to jabber, receive error, page received, parallel-detect fault, link-partner acknowledge, link status change, remote fault and auto-negotiation complete, in that order. `ev_in` uses the same positions. The enable for status bit i is register bit i+8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_in | input | 8 | Event inputs, positions as in R9 |
| sel | input | 1 | Register address decoded as this register |
| rd_en | input | 1 | Read strobe; a selected read clears the status byte |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data; only bits 15..8 are stored |
| polarity | input | 1 | 1: interrupt active high, 0: active low |
| rdata | output | 16 | Read data {enable, status}, zero when not selected |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench places events in the same cycle as a clearing read. A design that applies the clear after the set would drop those events. It holds an edge-type input high across a clear. A level-sensitive design would set that bit again at once. It writes all-ones to the status byte and issues reads and writes with `sel` low; a design that decodes badly would set or clear bits it must not touch. It also walks a single enable and a single event through each of the eight positions under both polarities, which catches swapped bit order and an inverted interrupt level.

// File: rtl/phy_irq_pkg.sv
// Package phy_irq_pkg
// Shared sizes, types and bit positions for the PHY event interrupt register.
// Assumes eight events; the bit positions below are the register layout.
package phy_irq_pkg;

    localparam int unsigned EVT_W = 8;

    typedef logic [EVT_W-1:0] evt_vec_t;

    // Status bit positions (enable bit is position + EVT_W)
    localparam int unsigned B_JABBER   = 7;
    localparam int unsigned B_RXERR    = 6;
    localparam int unsigned B_PAGE     = 5;
    localparam int unsigned B_PDFAULT  = 4;
    localparam int unsigned B_LPACK    = 3;
    localparam int unsigned B_LINKCHG  = 2;
    localparam int unsigned B_RFAULT   = 1;
    localparam int unsigned B_ANDONE   = 0;

    // Default choice of edge-detected inputs: receive error, link status
    // change, remote fault, auto-negotiation complete
    localparam logic [EVT_W-1:0] EDGE_MASK_DEF =
        (EVT_W'(1) << B_RXERR) | (EVT_W'(1) << B_LINKCHG) |
        (EVT_W'(1) << B_RFAULT) | (EVT_W'(1) << B_ANDONE);

endpackage

// File: rtl/phy_irq_evt_cond.sv
// Module phy_irq_evt_cond
// Turns raw event inputs into one-cycle set requests. Inputs selected by
// EDGE_MASK are rising-edge detected against a registered copy; the rest
// pass through as strobes. Assumes inputs are synchronous to clk.
module phy_irq_evt_cond #(
    parameter int unsigned     N         = 8,
    parameter logic [N-1:0]    EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_in,
    output logic [N-1:0] ev_set
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;

            // Remember last sampled level for rising-edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= ev_in[i];
            end

            assign ev_set[i] = ev_in[i] & ~prev_q;
        end else begin : g_strobe
            assign ev_set[i] = ev_in[i];
        end
    end

endmodule

// File: rtl/phy_irq_status.sv
// Module phy_irq_status
// Sticky status byte. Bits are set by set requests and cleared as a group
// by a clear pulse; a set in the clearing cycle wins.
module phy_irq_status #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_set,
    input  logic         clr,
    output logic [N-1:0] status_q
);

    logic [N-1:0] status_d;

    // Next state: keep unless cleared, then OR in new events
    always_comb begin
        status_d = (clr ? '0 : status_q) | ev_set;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

endmodule

// File: rtl/phy_irq_enable.sv
// Module phy_irq_enable
// Enable byte, loaded from the upper half of a register write.
module phy_irq_enable #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata_hi,
    output logic [N-1:0] enable_q
);

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)  enable_q <= '0;
        else if (wr) enable_q <= wdata_hi;
    end

endmodule

// File: rtl/phy_irq_reg.sv
// Module phy_irq_reg
// PHY event interrupt register: {enable[N-1:0], status[N-1:0]}.
// Status is sticky and clears on a selected read; enables are written
// from the upper half of wdata. irq_o follows the masked OR of status,
// at the level chosen by polarity. Assumes sel is an address decode that
// is valid in the same cycle as rd_en / wr_en.
module phy_irq_reg
    import phy_irq_pkg::*;
#(
    parameter int unsigned         EVT_N     = EVT_W,
    parameter logic [EVT_N-1:0]    EDGE_MASK = EDGE_MASK_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_N-1:0]     ev_in,
    input  logic                 sel,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [2*EVT_N-1:0]   wdata,
    input  logic                 polarity,
    output logic [2*EVT_N-1:0]   rdata,
    output logic                 irq_o
);

    localparam int unsigned REG_W = 2 * EVT_N;

    logic               rd_hit;
    logic               wr_hit;
    logic [EVT_N-1:0]   ev_set;
    logic [EVT_N-1:0]   status_q;
    logic [EVT_N-1:0]   enable_q;
    logic               pending;
    logic               unused_wdata_lo;

    // Decode accesses to this register
    always_comb begin
        rd_hit = sel & rd_en;
        wr_hit = sel & wr_en;
    end

    // Low half of write data is deliberately not stored
    assign unused_wdata_lo = ^wdata[EVT_N-1:0];

    phy_irq_evt_cond #(
        .N         (EVT_N),
        .EDGE_MASK (EDGE_MASK)
    ) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_in  (ev_in),
        .ev_set (ev_set)
    );

    phy_irq_status #(
        .N (EVT_N)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_set   (ev_set),
        .clr      (rd_hit),
        .status_q (status_q)
    );

    phy_irq_enable #(
        .N (EVT_N)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_hit),
        .wdata_hi (wdata[REG_W-1:EVT_N]),
        .enable_q (enable_q)
    );

    // Read mux: register contents only while selected
    always_comb begin
        rdata = sel ? {enable_q, status_q} : '0;
    end

    // Interrupt: masked OR, then polarity
    always_comb begin
        pending = |(status_q & enable_q);
        irq_o   = polarity ? pending : ~pending;
    end

endmodule

// File: rtl/phy_irq_reg_chk.sv
// Module phy_irq_reg_chk
// Assertion checker for phy_irq_reg, attached by bind below.
module phy_irq_reg_chk #(
    parameter int unsigned N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sel,
    input logic           rd_en,
    input logic           wr_en,
    input logic [N-1:0]   wdata_hi,
    input logic           polarity,
    input logic [N-1:0]   ev_set,
    input logic [N-1:0]   status_q,
    input logic [N-1:0]   enable_q,
    input logic [2*N-1:0] rdata,
    input logic           irq_o
);

    // R2: without a clearing read, set bits stay set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: a bit rises only when the condition logic requested it
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ev_set)) == '0));

    // R4: a selected read with no new event empties the status byte
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && ev_set == '0) |=> (status_q == '0));

    // R5: requested sets always land, even during a clearing read
    p_event_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((status_q & $past(ev_set)) == $past(ev_set)));

    // R6: enables move only on a selected write, and take the upper half
    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=> $stable(enable_q));
    p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en) |=> (enable_q == $past(wdata_hi)));

    // R7: nothing enabled and set means inactive level
    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == '0) |-> (irq_o == !polarity));

    // R8: unselected register reads as zero
    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0));

endmodule

bind phy_irq_reg phy_irq_reg_chk #(.N(EVT_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata_hi (wdata[2*EVT_N-1:EVT_N]),
    .polarity (polarity),
    .ev_set   (ev_set),
    .status_q (status_q),
    .enable_q (enable_q),
    .rdata    (rdata),
    .irq_o    (irq_o)
);

// File: tb/phy_irq_reg_bench.sv
// Bench for phy_irq_reg: a vector table walked one step per clock, then
// directed reset and per-bit tests. Inputs change on the falling edge,
// outputs are sampled 1 ns later.
module phy_irq_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev_in = '0;
    logic        sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        polarity = 1'b1;
    logic [15:0] rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    phy_irq_reg u_phy_irq_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_in    (ev_in),
        .sel      (sel),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .polarity (polarity),
        .rdata    (rdata),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Vector: {ev, sel, rd, wr, wdata, pol, exp_rdata, exp_irq}
    localparam int NV = 25;
    localparam logic [44:0] VEC [NV] = '{
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R1 state after reset
        {8'h80, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R2 jabber strobe
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0080, 1'b0}, // R2 R9 bit 7 set
        {8'h00, 1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b1, 16'h0080, 1'b0}, // R6 write all ones
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFF80, 1'b1}, // R6 low byte kept, R7
        {8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hFF80, 1'b1}, // R4 read shows old
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFF00, 1'b0}, // R4 cleared
        {8'h40, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R3 rx error rises
        {8'h40, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hFF40, 1'b1}, // R3 held, read clears
        {8'h40, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hFF00, 1'b0}, // R3 held level no reset
        {8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R3 release
        {8'h40, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hFF00, 1'b0}, // R5 rise during read
        {8'h20, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'hFF40, 1'b0}, // R5 kept, R7 active low
        {8'h20, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'hFF60, 1'b0}, // R5 strobe during read
        {8'h00, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 16'hFF20, 1'b0}, // R6 clear enables
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0020, 1'b1}, // R7 inactive high
        {8'h0F, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R2 R3 mixed events
        {8'h00, 1'b1, 1'b0, 1'b1, 16'h0100, 1'b1, 16'h002F, 1'b0}, // R9 positions 3..0
        {8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h012F, 1'b1}, // R7 bit 0 enabled
        {8'h07, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0100, 1'b0}, // R3 edges again
        {8'h00, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b1, 16'h0000, 1'b1}, // R8 write unselected
        {8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R8 read unselected
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0107, 1'b1}, // R8 nothing changed
        {8'h10, 1'b1, 1'b1, 1'b1, 16'h1000, 1'b1, 16'h0107, 1'b1}, // R5 R6 read+write+event
        {8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1010, 1'b1}  // R5 R6 result
    };

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        sel = 1'b1;
        #1;
        check("R1 rdata in reset", rdata, 16'h0000);
        check("R1 irq in reset", {15'b0, irq_o}, 16'h0000);
        rst_n = 1'b1;
        sel = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {ev_in, sel, rd_en, wr_en, wdata, polarity} = VEC[k][44:17];
            #1;
            check($sformatf("vector %0d rdata", k), rdata, VEC[k][16:1]);
            check($sformatf("vector %0d irq R7", k), {15'b0, irq_o}, {15'b0, VEC[k][0]});
        end

        // R1: reset in mid-run with enable 0x10 and status 0x10 set
        @(negedge clk);
        {ev_in, rd_en, wr_en, wdata} = '0;
        sel = 1'b1;
        polarity = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 mid-run reset rdata", rdata, 16'h0000);
        check("R1 mid-run reset irq", {15'b0, irq_o}, 16'h0000);
        polarity = 1'b0;
        #1;
        check("R1 R7 reset irq active low idle", {15'b0, irq_o}, 16'h0001);
        polarity = 1'b1;
        rst_n = 1'b1;

        // R9: each position, single enable, single event
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sel = 1'b1; wr_en = 1'b1; rd_en = 1'b0;
            wdata = {8'(1 << i), 8'h00};
            ev_in = '0;
            @(negedge clk);
            sel = 1'b0; wr_en = 1'b0;
            ev_in = 8'(1 << i);
            @(negedge clk);
            ev_in = '0;
            sel = 1'b1; rd_en = 1'b1;
            #1;
            check($sformatf("R9 bit %0d rdata", i), rdata, {8'(1 << i), 8'(1 << i)});
            check($sformatf("R9 bit %0d irq", i), {15'b0, irq_o}, 16'h0001);
            @(negedge clk);
            rd_en = 1'b0;
            #1;
            check($sformatf("R4 bit %0d cleared", i), rdata, {8'(1 << i), 8'h00});
            check($sformatf("R7 bit %0d irq idle", i), {15'b0, irq_o}, 16'h0000);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule